// File: doc/BRIEF.md
# Command-Driven SPI Word Transfer Engine

This block moves one SPI word per command. Software fills a bank of four 32-bit data registers, then writes a command word. The command gives the word length (1 to 128 bits), which of four chip selects to use, whether the single shared data line is used in both directions, and whether the word is sent or received. The engine shifts the word most significant bit first, paced by two single-cycle strobes from an external clock divider. One strobe marks the SCLK rising (sample) edge and the other the falling (launch) edge. Progress is shown by a busy bit and a word-complete bit.

A chip select is driven active by the first read or write command that names it. It stays active through the following commands, so a frame can span many words. Only an invalidate command releases it. The active level of each chip select comes from a per-line polarity register. Received bits land in the low bits of the data bank, so a short word is read back from data word 0.

Top module: `spi_word_engine`

## Requirements
- R1: After reset, busy and word-complete are 0, the polarity register is 0, every chip-select output is at its inactive level (all ones), spi_sclk is 0 and a status read (address 5) returns 0.
- R2: Register addresses are: 0 command, 1..4 data words 0..3, 5 status, 6 polarity. In the command word, bits 25:19 hold the length minus one, bits 29:28 the chip-select index, bit 26 the three-pin flag and bits 18:16 the type (1 read, 2 write, 4 invalidate). Any other type code, 7 included, starts nothing and changes no output. Bits 11:0 are a frame length that has no effect.
- R3: Status bit 1 is word-complete and bit 0 is busy. The cycle after an accepted read or write, busy is 1 and word-complete is 0. On the clock edge that takes the falling strobe of the last bit, busy drops to 0 and word-complete rises to 1. The two are never 1 together.
- R4: A write sends the low L bits of {data3,data2,data1,data0}, most significant first. mosi shows the first bit from the cycle after the command and moves to the next bit after each accepted falling strobe.
- R5: A read samples one bit on each accepted rising strobe. At completion, the low L bits of {data3,data2,data1,data0} hold the received bits, first arrival most significant, and every higher bit of the bank is 0.
- R6: The selected chip select becomes active in the cycle after an accepted read or write. It stays active after completion and until an invalidate command. A later command naming another index moves the selection to that index.
- R7: Polarity bit i gives the active level of chip select i. The inactive level is its inverse.
- R8: In three-pin mode a read holds mosi_oe at 0 and samples sio_in. A normal read samples miso. In all other cases mosi_oe is 1.
- R9: Writes to the command register or to the data registers while busy is 1 are ignored.
- R10: spi_sclk goes to 1 on a rising strobe and to 0 on a falling strobe, only while busy. A falling strobe while spi_sclk is 0 does not shift.
- R11: The length limits work: a 1-bit word and a 128-bit word both transfer correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| sclk_rise | input | 1 | Rising-edge (sample) strobe from the divider |
| sclk_fall | input | 1 | Falling-edge (launch) strobe from the divider |
| miso | input | 1 | Serial input, normal mode |
| sio_in | input | 1 | Read-back of the shared data line, three-pin mode |
| spi_sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output / shared data line |
| mosi_oe | output | 1 | Output enable for mosi |
| spi_cs | output | 4 | Chip selects, level set by polarity |
| stat_wc | output | 1 | Word complete |
| stat_busy | output | 1 | Busy |

## Verification
Writes are tried with a mixed 8-bit pattern, a 1-bit word and a 128-bit word whose four data words each differ. These show whether the bit order is right, whether the word boundary is taken from the length field, and whether the data words are chained in the right order. Reads feed different values on miso and sio_in, so the bench can tell which line is sampled in each mode. The data bank is preset to all ones before a read, which shows whether the upper bits are cleared. Commands written mid-transfer, an invalid type code and a stray falling strobe separate ignored stimulus from accepted stimulus. Polarity changes separate the active chip-select level from the inactive one.

// File: rtl/spi_we_pkg.sv
package spi_we_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 4;
    localparam int MAX_LEN   = WORD_W * NUM_WORDS;
    localparam int NUM_CS    = 4;
    localparam int ADDR_W    = 3;

    // command word field positions
    localparam int LEN_LSB  = 19;
    localparam int LEN_W    = 7;
    localparam int CS_LSB   = 28;
    localparam int CS_W     = 2;
    localparam int TP_BIT   = 26;
    localparam int TYPE_LSB = 16;

    localparam logic [2:0] TYPE_READ  = 3'd1;
    localparam logic [2:0] TYPE_WRITE = 3'd2;
    localparam logic [2:0] TYPE_INVAL = 3'd4;

    typedef enum logic [ADDR_W-1:0] {
        A_CMD  = 3'd0,
        A_D0   = 3'd1,
        A_D1   = 3'd2,
        A_D2   = 3'd3,
        A_D3   = 3'd4,
        A_STAT = 3'd5,
        A_POL  = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_READ,
        K_WRITE,
        K_INVAL
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e        kind;
        logic             three_pin;
        logic [CS_W-1:0]  cs_idx;
        logic [LEN_W-1:0] len_m1;
    } cmd_t;

    function automatic cmd_kind_e kind_of(input logic [2:0] code);
        case (code)
            TYPE_READ:  return K_READ;
            TYPE_WRITE: return K_WRITE;
            TYPE_INVAL: return K_INVAL;
            default:    return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_we_data_bank.sv
module spi_we_data_bank
    import spi_we_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int N     = NUM_WORDS,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_wr,
    input  logic [IDXW-1:0] host_idx,
    input  logic [W-1:0]   host_data,
    input  logic           rx_load,
    input  logic [W*N-1:0] rx_word,
    output logic [W*N-1:0] bank
);

    for (genvar g = 0; g < N; g++) begin : g_word
        logic [W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (rx_load) begin
                word_q <= rx_word[g*W +: W];
            end else if (host_wr && host_idx == IDXW'(g)) begin
                word_q <= host_data;
            end
        end
        assign bank[g*W +: W] = word_q;
    end

endmodule

// File: rtl/spi_we_shifter.sv
module spi_we_shifter
    import spi_we_pkg::*;
#(
    parameter int L_MAX  = MAX_LEN,
    localparam int LW    = $clog2(L_MAX),
    localparam int CW    = $clog2(L_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_read,
    input  logic             start_three,
    input  logic [LW-1:0]    start_len_m1,
    input  logic [L_MAX-1:0] tx_word,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             miso,
    input  logic             sio_in,
    output logic             busy,
    output logic             wc,
    output logic             rx_load,
    output logic [L_MAX-1:0] rx_word,
    output logic             sclk,
    output logic             mosi,
    output logic             mosi_oe
);

    logic             busy_q, wc_q, sclk_q, smp_q, read_q, three_q;
    logic [LW-1:0]    len_q;
    logic [CW-1:0]    cnt_q;
    logic [L_MAX-1:0] sh_q;
    logic [L_MAX-1:0] sh_next;
    logic [L_MAX-1:0] keep_mask;
    logic             take_rise, take_fall, last_bit;

    assign take_rise = busy_q && sclk_rise && !sclk_q;
    assign take_fall = busy_q && sclk_fall && sclk_q;
    assign last_bit  = (cnt_q == CW'(1));
    assign sh_next   = {sh_q[L_MAX-2:0], smp_q};

    always_comb begin
        for (int i = 0; i < L_MAX; i++) begin
            keep_mask[i] = (i <= int'(len_q));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            wc_q    <= 1'b0;
            sclk_q  <= 1'b0;
            smp_q   <= 1'b0;
            read_q  <= 1'b0;
            three_q <= 1'b0;
            len_q   <= '0;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            wc_q    <= 1'b0;
            sclk_q  <= 1'b0;
            read_q  <= start_read;
            three_q <= start_three;
            len_q   <= start_len_m1;
            cnt_q   <= CW'(start_len_m1) + CW'(1);
            sh_q    <= tx_word;
        end else begin
            if (take_rise) begin
                sclk_q <= 1'b1;
                smp_q  <= three_q ? sio_in : miso;
            end
            if (take_fall) begin
                sclk_q <= 1'b0;
                sh_q   <= sh_next;
                cnt_q  <= cnt_q - CW'(1);
                if (last_bit) begin
                    busy_q <= 1'b0;
                    wc_q   <= 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign wc      = wc_q;
    assign sclk    = sclk_q;
    assign mosi    = sh_q[len_q];
    assign mosi_oe = !(busy_q && read_q && three_q);
    assign rx_load = take_fall && last_bit && read_q;
    assign rx_word = sh_next & keep_mask;

    // R3
    no_wc_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_q && wc_q));

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy_q && !wc_q));

    // R10
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sclk_q);

endmodule

// File: rtl/spi_we_cs_ctrl.sv
module spi_we_cs_ctrl
    import spi_we_pkg::*;
#(
    parameter int N    = NUM_CS,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open_cs,
    input  logic [IW-1:0] open_idx,
    input  logic          close_cs,
    input  logic [N-1:0]  pol,
    output logic [N-1:0]  cs_out,
    output logic          active
);

    logic          active_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (open_cs) begin
            active_q <= 1'b1;
            idx_q    <= open_idx;
        end else if (close_cs) begin
            active_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        assign cs_out[g] = (active_q && idx_q == IW'(g)) ? pol[g] : !pol[g];
    end

    assign active = active_q;

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
    import spi_we_pkg::*;
#(
    parameter int DW      = WORD_W,
    parameter int DN      = NUM_WORDS,
    parameter int CSN     = NUM_CS,
    localparam int BITS   = DW * DN,
    localparam int DIDX_W = (DN > 1) ? $clog2(DN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              miso,
    input  logic              sio_in,
    output logic              spi_sclk,
    output logic              mosi,
    output logic              mosi_oe,
    output logic [CSN-1:0]    spi_cs,
    output logic              stat_wc,
    output logic              stat_busy
);

    cmd_t             cmd;
    logic             cmd_wr, data_wr, start, inval;
    logic [31:0]      cmd_q;
    logic [CSN-1:0]   pol_q;
    logic [BITS-1:0]  bank, rx_word;
    logic             rx_load, busy, wc, cs_active;
    logic [DIDX_W-1:0] data_idx;
    logic [ADDR_W-1:0] addr_off;

    always_comb begin
        cmd.kind      = kind_of(reg_wdata[TYPE_LSB +: 3]);
        cmd.three_pin = reg_wdata[TP_BIT];
        cmd.cs_idx    = reg_wdata[CS_LSB +: CS_W];
        cmd.len_m1    = reg_wdata[LEN_LSB +: LEN_W];
    end

    assign addr_off = reg_addr - ADDR_W'(A_D0);
    assign data_idx = addr_off[DIDX_W-1:0];
    assign cmd_wr   = reg_wr && reg_addr == A_CMD && !busy;
    assign data_wr  = reg_wr && !busy && reg_addr >= A_D0 &&
                      int'(reg_addr) < int'(A_D0) + DN;
    assign start    = cmd_wr && (cmd.kind == K_READ || cmd.kind == K_WRITE);
    assign inval    = cmd_wr && cmd.kind == K_INVAL;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            pol_q <= '0;
        end else begin
            if (cmd_wr) cmd_q <= reg_wdata;
            if (reg_wr && reg_addr == A_POL) pol_q <= reg_wdata[CSN-1:0];
        end
    end

    spi_we_data_bank #(.W(DW), .N(DN)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .host_wr  (data_wr),
        .host_idx (data_idx),
        .host_data(reg_wdata[DW-1:0]),
        .rx_load  (rx_load),
        .rx_word  (rx_word),
        .bank     (bank)
    );

    spi_we_shifter #(.L_MAX(BITS)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_read  (cmd.kind == K_READ),
        .start_three (cmd.three_pin),
        .start_len_m1(cmd.len_m1),
        .tx_word     (bank),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .miso        (miso),
        .sio_in      (sio_in),
        .busy        (busy),
        .wc          (wc),
        .rx_load     (rx_load),
        .rx_word     (rx_word),
        .sclk        (spi_sclk),
        .mosi        (mosi),
        .mosi_oe     (mosi_oe)
    );

    spi_we_cs_ctrl #(.N(CSN)) u_cs (
        .clk     (clk),
        .rst     (rst),
        .open_cs (start),
        .open_idx(cmd.cs_idx),
        .close_cs(inval),
        .pol     (pol_q),
        .cs_out  (spi_cs),
        .active  (cs_active)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CMD) begin
            reg_rdata = cmd_q;
        end else if (reg_addr == A_STAT) begin
            reg_rdata = {30'd0, wc, busy};
        end else if (reg_addr == A_POL) begin
            reg_rdata = 32'(pol_q);
        end else if (reg_addr >= A_D0 && int'(reg_addr) < int'(A_D0) + DN) begin
            reg_rdata = 32'(bank[int'(data_idx)*DW +: DW]);
        end
    end

    assign stat_busy = busy;
    assign stat_wc   = wc;

    // R6
    busy_cs_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> cs_active);

    // R9
    cmd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CMD && busy) |=> $stable(cmd_q));

    // R9
    no_load_clash_chk: assert property (@(posedge clk) disable iff (rst)
        rx_load |-> !data_wr);

endmodule

// File: tb/sim_spi_word_engine.sv
module sim_spi_word_engine;

    logic        clk = 0;
    logic        rst = 1;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        sclk_rise = 0, sclk_fall = 0, miso = 0, sio_in = 0;
    logic        spi_sclk, mosi, mosi_oe, stat_wc, stat_busy;
    logic [3:0]  spi_cs;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_word_engine u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .miso(miso),
        .sio_in(sio_in), .spi_sclk(spi_sclk), .mosi(mosi), .mosi_oe(mosi_oe),
        .spi_cs(spi_cs), .stat_wc(stat_wc), .stat_busy(stat_busy)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input int kind, input int cs,
                                           input int len, input bit three);
        return (32'(cs) << 28) | (32'(three) << 26) | (32'(len - 1) << 19) |
               (32'(kind) << 16) | 32'hFFF;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // one bit: sample mosi, drive inputs, rising strobe, falling strobe
    task automatic spi_bit(input bit m_in, input bit s_in, output bit out_b,
                           output bit sclk_hi);
        out_b = mosi;
        miso = m_in; sio_in = s_in; sclk_rise = 1;
        @(negedge clk);
        sclk_rise = 0;
        sclk_hi = spi_sclk;
        sclk_fall = 1;
        @(negedge clk);
        sclk_fall = 0;
    endtask

    task automatic run_word(input int len, input logic [127:0] m_vec,
                            input logic [127:0] s_vec, output logic [127:0] out_vec);
        bit b, h;
        out_vec = '0;
        for (int i = len - 1; i >= 0; i--) begin
            spi_bit(m_vec[i], s_vec[i], b, h);
            out_vec[i] = b;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check(!stat_busy && !stat_wc, "R1 status", {stat_wc, stat_busy}, 0);
        check(spi_cs == 4'hF, "R1 cs idle", spi_cs, 4'hF);
        check(spi_sclk == 0, "R1 sclk", spi_sclk, 0);
        rd(5, d);
        check(d == 0, "R1 status reg", d, 0);
    endtask

    task automatic t_write8;
        logic [127:0] o;
        logic [31:0] d;
        wr(1, 32'hA5);
        wr(0, mk_cmd(2, 0, 8, 0));
        check(stat_busy && !stat_wc, "R3 busy after cmd", {stat_wc, stat_busy}, 1);
        check(spi_cs == 4'b1110, "R6 cs0 active", spi_cs, 4'b1110);
        check(mosi_oe == 1, "R8 oe on write", mosi_oe, 1);
        run_word(8, 0, 0, o);
        check(o[7:0] == 8'hA5, "R4 write bits", o[7:0], 8'hA5);
        check(!stat_busy && stat_wc, "R3 done", {stat_wc, stat_busy}, 2);
        rd(5, d);
        check(d == 2, "R3 status reg", d, 2);
        check(spi_cs == 4'b1110, "R6 cs held", spi_cs, 4'b1110);
    endtask

    task automatic t_ignore_busy;
        logic [127:0] o;
        logic [31:0] d;
        bit b, h;
        wr(1, 32'h5A);
        wr(0, mk_cmd(2, 1, 8, 0));
        check(spi_cs == 4'b1101, "R6 moves to cs1", spi_cs, 4'b1101);
        run_word(3, 0, 0, o);
        wr(0, mk_cmd(2, 3, 4, 0));
        wr(1, 32'hFF);
        check(spi_cs == 4'b1101, "R9 cmd ignored cs", spi_cs, 4'b1101);
        rd(1, d);
        check(d == 32'h5A, "R9 data ignored", d, 32'h5A);
        rd(0, d);
        check(d == mk_cmd(2, 1, 8, 0), "R9 cmd reg kept", d, mk_cmd(2, 1, 8, 0));
        for (int i = 0; i < 4; i++) spi_bit(0, 0, b, h);
        check(stat_busy, "R9 length kept", stat_busy, 1);
        spi_bit(0, 0, b, h);
        check(!stat_busy && stat_wc, "R3 8 bits", {stat_wc, stat_busy}, 2);
    endtask

    task automatic t_read8;
        logic [127:0] o;
        logic [31:0] d;
        for (int i = 1; i <= 4; i++) wr(3'(i), 32'hFFFF_FFFF);
        wr(0, mk_cmd(1, 1, 8, 0));
        check(mosi_oe == 1, "R8 oe normal read", mosi_oe, 1);
        run_word(8, 128'h3C, 128'hC3, o);
        rd(1, d);
        check(d == 32'h3C, "R5 R8 read data0", d, 32'h3C);
        rd(2, d);
        check(d == 0, "R5 upper cleared", d, 0);
        rd(4, d);
        check(d == 0, "R5 data3 cleared", d, 0);
    endtask

    task automatic t_three;
        logic [127:0] o;
        logic [31:0] d;
        wr(0, mk_cmd(1, 1, 8, 1));
        check(mosi_oe == 0, "R8 oe three-pin read", mosi_oe, 0);
        run_word(8, 128'h96, 128'h69, o);
        rd(1, d);
        check(d == 32'h69, "R8 three-pin sample", d, 32'h69);
        check(mosi_oe == 1, "R8 oe after", mosi_oe, 1);
    endtask

    task automatic t_wide;
        logic [127:0] o, exp;
        exp = 128'h8123_4567_0BAD_F00D_DEAD_BEEF_7654_3211;
        wr(1, exp[31:0]); wr(2, exp[63:32]); wr(3, exp[95:64]); wr(4, exp[127:96]);
        wr(0, mk_cmd(2, 2, 128, 0));
        check(mosi == 1, "R4 first bit data3 msb", mosi, 1);
        run_word(128, 0, 0, o);
        check(o == exp, "R11 R4 128-bit write", o, exp);
        check(stat_wc && !stat_busy, "R11 128 done", {stat_wc, stat_busy}, 2);
    endtask

    task automatic t_min;
        logic [127:0] o;
        logic [31:0] d;
        wr(1, 32'hFFFF_FFFE);
        wr(2, 0);
        wr(0, mk_cmd(2, 0, 1, 0));
        run_word(1, 0, 0, o);
        check(o[0] == 0 && stat_wc, "R11 1-bit write", o[0], 0);
        wr(0, mk_cmd(1, 0, 1, 0));
        run_word(1, 1, 0, o);
        rd(1, d);
        check(d == 1, "R11 1-bit read", d, 1);
    endtask

    task automatic t_sclk;
        bit b, h, m0;
        wr(1, 32'h2);
        wr(0, mk_cmd(2, 0, 2, 0));
        m0 = mosi;
        sclk_fall = 1;
        @(negedge clk);
        sclk_fall = 0;
        check(mosi == m0 && stat_busy, "R10 stray fall ignored", mosi, m0);
        spi_bit(0, 0, b, h);
        check(h == 1, "R10 sclk high", h, 1);
        check(b == 1 && spi_sclk == 0, "R10 sclk low after fall", {b, spi_sclk}, 2);
        spi_bit(0, 0, b, h);
        check(b == 0 && !stat_busy, "R4 second bit", b, 0);
    endtask

    task automatic t_inval_code7;
        logic [31:0] d;
        wr(0, mk_cmd(4, 0, 8, 0));
        check(spi_cs == 4'hF, "R6 invalidate", spi_cs, 4'hF);
        wr(0, mk_cmd(7, 2, 8, 0));
        check(!stat_busy && spi_cs == 4'hF, "R2 code 7 ignored", {stat_busy, spi_cs}, 4'hF);
        rd(5, d);
        check(d == 2, "R2 status unchanged", d, 2);
    endtask

    task automatic t_pol;
        logic [127:0] o;
        wr(6, 32'h4);
        check(spi_cs == 4'b1011, "R7 idle level", spi_cs, 4'b1011);
        wr(0, mk_cmd(2, 2, 2, 0));
        check(spi_cs == 4'b1111, "R7 active high cs2", spi_cs, 4'b1111);
        run_word(2, 0, 0, o);
        wr(0, mk_cmd(4, 2, 2, 0));
        check(spi_cs == 4'b1011, "R7 released", spi_cs, 4'b1011);
        wr(6, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_write8();
        t_ignore_busy();
        t_read8();
        t_three();
        t_wide();
        t_min();
        t_sclk();
        t_inval_code7();
        t_pol();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule